// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory. A burst begins when a start address is captured from the external address input. After that, each advance step changes only the two least significant address bits. They follow either a wrapping linear count or an interleaved order, and the interleaved order is the start value XOR the beat number. The address bits above the beat field are held for the whole burst.

Controls are split across separate inputs:
- A load/advance select chooses between starting a new burst and stepping the current one.
- A chip-select qualifies a load.
- A clock-hold input makes the block ignore a clock edge completely.
- An ordering input chooses linear or interleaved order. It is captured together with each new start address.

The address output is registered and changes one clock edge after the controls are sampled.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, the address output becomes all zeros after that edge.
- R2: With step_sel low, chip_sel high and hold_clk low, the address output equals ext_addr after the edge.
- R3: With order_sel captured as 0 (linear), each advance (step_sel high, hold_clk low) adds one modulo four to bits [1:0]. From a start of 01, the sequence is 01, 10, 11, 00.
- R4: With order_sel captured as 1 (interleaved), bits [1:0] equal the start value XOR the beat number. A start of 10 gives 10, 11, 00, 01, and a start of 11 gives 11, 10, 01, 00.
- R5: With hold_clk high, the edge is ignored. The address output keeps its value whatever the other inputs are.
- R6: Advancing never changes address bits above bit 1, including when the linear count wraps from 11 to 00.
- R7: The advance that follows the fourth beat returns to the start address of the same burst.
- R8: order_sel is sampled only on a load. Changing it during a burst does not change that burst's ordering.
- R9: With step_sel low and chip_sel low, the edge is a deselect. The address output is unchanged and ext_addr is not captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | Start address offered for a new burst |
| step_sel | input | 1 | 0 = load a new burst, 1 = advance the current one |
| chip_sel | input | 1 | High enables a load; low makes a load cycle a deselect |
| hold_clk | input | 1 | High makes the block ignore the clock edge |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order; sampled on load |
| word_addr | output | ADDR_W | Current burst word address |

## Verification
Every result of this block is due exactly one rising edge after its controls are sampled. This applies to a capture, an advance step, a held edge, a deselect and a reset. The driver applies each cycle's inputs at the falling edge and queues the address expected after the next rising edge. The monitor removes and compares that entry 1 ns after the rising edge, so each comparison falls in the cycle where the single output register has updated and away from the edge itself.

// File: rtl/bsq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bsq_pkg;

    // Ordering of the beat bits inside a burst.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Action taken at one clock edge.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2,
        ACT_HOLD = 2'd3
    } act_e;

endpackage

// File: rtl/bsq_ctrl.sv
// Control decode: turns the edge-level controls into a single action.
// Hold has the highest priority, then advance, then load or deselect.
// Assumes: all inputs are synchronous to the sampling clock.
module bsq_ctrl
    import bsq_pkg::*;
(
    input  logic step_sel,
    input  logic chip_sel,
    input  logic hold_clk,
    output act_e act
);

    // Priority decode of the control inputs.
    always_comb begin
        if (hold_clk) begin
            act = ACT_HOLD;
        end else if (step_sel) begin
            act = ACT_STEP;
        end else if (chip_sel) begin
            act = ACT_LOAD;
        end else begin
            act = ACT_IDLE;
        end
    end

endmodule

// File: rtl/bsq_state.sv
// Burst state: start address, beat counter and the ordering captured on load.
// Assumes: synchronous active-low reset; act decoded by bsq_ctrl.
module bsq_state
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] cnt_q,
    output order_e            mode_q
);

    // Capture on load, count beats on advance, keep everything otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            mode_q <= ORD_LINEAR;
        end else begin
            case (act)
                ACT_LOAD: begin
                    base_q <= ext_addr;
                    cnt_q  <= '0;
                    mode_q <= order_e'(order_sel);
                end
                ACT_STEP: begin
                    cnt_q <= cnt_q + BEAT_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

    // R8: the ordering of a running burst is frozen between loads.
    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act != ACT_LOAD) |=> (mode_q == $past(mode_q)));

    // R6: the start address never moves except on a load.
    p_base_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP) |=> (base_q == $past(base_q)));

endmodule

// File: rtl/bsq_order.sv
// Beat-bit generator: maps start bits and beat count to the low address bits.
// Assumes: BEAT_W bits cover one burst, so both orders wrap naturally.
module bsq_order
    import bsq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] cnt,
    input  order_e            mode,
    output logic [BEAT_W-1:0] low
);

    // Select linear sum or XOR interleave of start and beat number.
    always_comb begin
        if (mode == ORD_INTERLEAVE) begin
            low = start ^ cnt;
        end else begin
            low = start + cnt;
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top: registered word address of a four-beat burst.
// Upper bits come from the captured start; beat bits follow the captured order.
// Assumes: synchronous active-low reset; output valid one edge after controls.
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              step_sel,
    input  logic              chip_sel,
    input  logic              hold_clk,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    act_e              act;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    order_e            mode_q;
    logic [BEAT_W-1:0] low;

    bsq_ctrl u_ctrl (
        .step_sel (step_sel),
        .chip_sel (chip_sel),
        .hold_clk (hold_clk),
        .act      (act)
    );

    bsq_state #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .ext_addr  (ext_addr),
        .order_sel (order_sel),
        .base_q    (base_q),
        .cnt_q     (cnt_q),
        .mode_q    (mode_q)
    );

    bsq_order #(.BEAT_W(BEAT_W)) u_order (
        .start (base_q[BEAT_W-1:0]),
        .cnt   (cnt_q),
        .mode  (mode_q),
        .low   (low)
    );

    // Join the fixed upper bits with the sequenced beat bits.
    always_comb begin
        word_addr = {base_q[ADDR_W-1:BEAT_W], low};
    end

    // R1: reset clears the address.
    p_reset_zero_r1: assert property (@(posedge clk)
        (!rst_n) |=> (word_addr == '0));

    // R2: an enabled load presents the external address next cycle.
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clk && !step_sel && chip_sel) |=> (word_addr == $past(ext_addr)));

    // R3: a linear advance adds one to the beat bits.
    p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clk && step_sel && mode_q == ORD_LINEAR)
        |=> (word_addr[BEAT_W-1:0] == BEAT_W'($past(word_addr[BEAT_W-1:0]) + 1'b1)));

    // R5: a held edge changes nothing.
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clk |=> $stable(word_addr));

    // R6: advancing keeps the upper bits.
    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clk && step_sel)
        |=> (word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W])));

    // R9: a deselect edge keeps the address.
    p_deselect_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clk && !step_sel && !chip_sel) |=> $stable(word_addr));

    // R6: the upper field width must be positive.
    initial begin
        a_upper_width_r6: assert (UPPER_W > 0);
    end

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          step_sel = 1'b0;
    logic          chip_sel = 1'b0;
    logic          hold_clk = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] word_addr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_addr  (ext_addr),
        .step_sel  (step_sel),
        .chip_sel  (chip_sel),
        .hold_clk  (hold_clk),
        .order_sel (order_sel),
        .word_addr (word_addr)
    );

    // Driver: apply one cycle of inputs at the falling edge and queue the result due.
    task automatic drive(input logic rn, input logic adv, input logic ce,
                         input logic hold, input logic mode, input logic [AW-1:0] a,
                         input logic [AW-1:0] exp, input string tag);
        @(negedge clk);
        rst_n     = rn;
        step_sel  = adv;
        chip_sel  = ce;
        hold_clk  = hold;
        order_sel = mode;
        ext_addr  = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare 1 ns after each rising edge against the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [AW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (word_addr !== e) begin
                    errors++;
                    $display("FAIL %s: word_addr=%h expected %h", t, word_addr, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        drive(0, 0, 0, 0, 0, 18'h3FFFF, 18'h00000, "R1");
        drive(0, 1, 1, 0, 1, 18'h12345, 18'h00000, "R1");
        // R2 load linear, then R3 / R6 / R7 walk
        drive(1, 0, 1, 0, 0, 18'h2A5C1, 18'h2A5C1, "R2");
        drive(1, 1, 1, 0, 0, 18'h15555, 18'h2A5C2, "R3");
        drive(1, 1, 1, 0, 0, 18'h15555, 18'h2A5C3, "R3");
        drive(1, 1, 0, 0, 0, 18'h15555, 18'h2A5C0, "R6");
        drive(1, 1, 1, 0, 0, 18'h15555, 18'h2A5C1, "R7");
        // R5: held edges ignore advance and load
        drive(1, 1, 1, 1, 1, 18'h3FFFF, 18'h2A5C1, "R5");
        drive(1, 0, 1, 1, 1, 18'h3FFFF, 18'h2A5C1, "R5");
        drive(1, 1, 1, 0, 0, 18'h3FFFF, 18'h2A5C2, "R3");
        // R9: deselect does not capture
        drive(1, 0, 0, 0, 1, 18'h00AAA, 18'h2A5C2, "R9");
        // R4: interleaved from 10
        drive(1, 0, 1, 0, 1, 18'h1F3E2, 18'h1F3E2, "R2");
        drive(1, 1, 1, 0, 1, 18'h00000, 18'h1F3E3, "R4");
        drive(1, 1, 1, 0, 1, 18'h00000, 18'h1F3E0, "R4");
        drive(1, 1, 1, 0, 1, 18'h00000, 18'h1F3E1, "R4");
        drive(1, 1, 1, 0, 1, 18'h00000, 18'h1F3E2, "R7");
        // R4: interleaved from 11
        drive(1, 0, 1, 0, 1, 18'h00007, 18'h00007, "R2");
        drive(1, 1, 0, 0, 1, 18'h3FFF0, 18'h00006, "R4");
        drive(1, 1, 0, 0, 1, 18'h3FFF0, 18'h00005, "R4");
        drive(1, 1, 0, 0, 1, 18'h3FFF0, 18'h00004, "R4");
        drive(1, 1, 0, 0, 1, 18'h3FFF0, 18'h00007, "R7");
        // R8: linear burst keeps linear order when order_sel rises
        drive(1, 0, 1, 0, 0, 18'h3FFFD, 18'h3FFFD, "R2");
        drive(1, 1, 1, 0, 1, 18'h00000, 18'h3FFFE, "R8");
        drive(1, 1, 1, 0, 1, 18'h00000, 18'h3FFFF, "R8");
        // R8: interleaved burst keeps its order when order_sel falls
        drive(1, 0, 1, 0, 1, 18'h12341, 18'h12341, "R2");
        drive(1, 1, 1, 0, 0, 18'h00000, 18'h12340, "R8");
        drive(1, 1, 1, 0, 0, 18'h00000, 18'h12343, "R8");
        // R1: reset in mid burst
        drive(0, 1, 1, 0, 0, 18'h00000, 18'h00000, "R1");
        drive(1, 0, 0, 0, 0, 18'h00000, 18'h00000, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule